// File: doc/BRIEF.md
# Acknowledged Packet Transmit Sequencer with Automatic Retry

This block runs the transmit side of a short-packet radio link that uses acknowledgements and retries. When the transmit queue holds an entry, the block reads the entry's length and no-acknowledge flag. It then shifts out a complete frame as a serial bit stream, one bit per clock and most significant bit first. The frame carries a station address, a 9-bit control field, the payload bytes and a trailing CRC. The CRC is 8 or 16 bits wide, selected by a configuration input. Payload bytes are fetched from the head entry of the queue through an index output, so the entry is never copied into the block.

A packet marked no-acknowledge completes as soon as its last bit leaves. Any other packet starts a retry timer and waits for an acknowledge strobe. The timer counts an external 1 µs tick. When the timer expires with no acknowledge, the frame is sent again, identical to the first, up to a configured number of retries. Two sticky status flags report the result to the host: one for success, one for retries exhausted. The host clears each flag by pulsing its clear input. While the retries-exhausted flag is set, the failed entry stays at the queue head and the block starts nothing new.

Top module: `arq_tx_ctrl`

## Requirements
- R1: A frame is sent with `tx_vld` high on every bit and no gaps, one bit per clock, most significant bit first. The order is: the ADDR_W-bit address; the control field {length[5:0], packet id[1:0], no-ack}; the payload bytes in index order 0 upward (none when length is 0); the CRC. `tx_last` is high only with the final CRC bit.
- R2: With `cfg_crc16`=1 the CRC is 16 bits, polynomial 0x1021, initial value 0xFFFF. With `cfg_crc16`=0 it is 8 bits, polynomial 0x07, initial value 0xFF. Both are computed bit-serially over the address, control and payload bits, and sent most significant bit first.
- R3: The packet id is 0 after reset and steps by 1 modulo 4 each time an entry is popped. A retransmission repeats the previous frame bit for bit, including the id.
- R4: For an entry with no-ack=1, `st_done` is set and `fifo_pop` pulses for one cycle with the final bit, without waiting for an acknowledge.
- R5: An `ack_in` pulse while waiting sets `st_done` and pops the entry, and no further frame is sent for that entry.
- R6: The retry wait lasts (cfg_retr[7:4]+1)*STEP_TICKS ticks. With `tick_us` held high, the first bit of a retry appears exactly (cfg_retr[7:4]+1)*STEP_TICKS+1 cycles after the final bit of the previous attempt.
- R7: With cfg_retr[3:0]=m and no acknowledge, exactly m+1 frames are sent. `st_maxrt` is then set, `st_done` stays clear and the entry is not popped.
- R8: While `st_maxrt` is set no frame starts. After `clr_maxrt` clears it, the head entry is sent again.
- R9: `st_done` and `st_maxrt` remain set until their clear input is pulsed.
- R10: After reset all outputs are low. With an empty queue no frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | 1 µs timing strobe for the retry wait |
| cfg_addr | input | ADDR_W | Destination address placed at the head of the frame |
| cfg_crc16 | input | 1 | 1 selects the 16-bit CRC, 0 the 8-bit CRC |
| cfg_retr | input | 8 | [7:4] retry delay step count minus one, [3:0] maximum retries |
| fifo_empty | input | 1 | Transmit queue holds no entry |
| fifo_len | input | 6 | Payload length of the head entry, 0 to MAX_LEN |
| fifo_noack | input | 1 | Head entry does not expect an acknowledge |
| pl_idx | output | $clog2(MAX_LEN) | Byte index into the head entry's payload |
| pl_byte | input | 8 | Payload byte at `pl_idx` |
| fifo_pop | output | 1 | One-cycle pulse that retires the head entry |
| ack_in | input | 1 | Acknowledge strobe from the receive side |
| clr_done | input | 1 | Clears `st_done` |
| clr_maxrt | input | 1 | Clears `st_maxrt` |
| tx_bit | output | 1 | Serial frame bit |
| tx_vld | output | 1 | `tx_bit` holds a frame bit |
| tx_last | output | 1 | Final bit of a frame |
| st_done | output | 1 | Sticky flag: packet delivered |
| st_maxrt | output | 1 | Sticky flag: retries exhausted |

## Verification
Frame content is swept over every payload length from 0 to 32. Consecutive lengths alternate between the two CRC widths, so header, payload indexing and both CRC polynomials are each compared bit for bit, and the packet id is seen to wrap. The retry count is swept over all sixteen values without an acknowledge, which separates an off-by-one in the retry limit from a failure to stop. The delay is measured for short, middle and longest nibble values, and the check shows that a blocked head entry is resent once the flag is cleared. Acknowledges arrive on the first and on a later attempt, to show that one acknowledge ends the packet whichever attempt it answers.

// File: rtl/arq_tx_pkg.sv
package arq_tx_pkg;
  localparam int CTRL_W = 9;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} tx_state_e;
  typedef enum logic [1:0] {G_ADDR, G_CTRL, G_PAY, G_CRC} seg_e;
endpackage

// File: rtl/arq_crc_ser.sv
module arq_crc_ser #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = '0,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] crc
);
  logic fb;
  assign fb = crc[W-1] ^ din;

  always_ff @(posedge clk) begin
    if (rst || init) crc <= INIT;
    else if (en)     crc <= {crc[W-2:0], 1'b0} ^ ({W{fb}} & POLY);
  end
endmodule

// File: rtl/arq_retry_timer.sv
module arq_retry_timer #(
  parameter int STEP_TICKS = 250
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] nib,
  input  logic       tick,
  output logic       expire
);
  localparam int CNT_W = $clog2(16 * STEP_TICKS + 1);
  localparam logic [CNT_W-1:0] STEP_C = CNT_W'(STEP_TICKS);

  logic [CNT_W-1:0] cnt;

  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= (CNT_W'(nib) + CNT_W'(1)) * STEP_C;
    else if (tick && cnt != '0) cnt <= cnt - CNT_W'(1);
  end
endmodule

// File: rtl/arq_tx_ctrl.sv
module arq_tx_ctrl
  import arq_tx_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MAX_LEN    = 32,
  parameter int STEP_TICKS = 250
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick_us,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic                       cfg_crc16,
  input  logic [7:0]                 cfg_retr,
  input  logic                       fifo_empty,
  input  logic [5:0]                 fifo_len,
  input  logic                       fifo_noack,
  output logic [$clog2(MAX_LEN)-1:0] pl_idx,
  input  logic [7:0]                 pl_byte,
  output logic                       fifo_pop,
  input  logic                       ack_in,
  input  logic                       clr_done,
  input  logic                       clr_maxrt,
  output logic                       tx_bit,
  output logic                       tx_vld,
  output logic                       tx_last,
  output logic                       st_done,
  output logic                       st_maxrt
);
  localparam int IDX_W  = $clog2(MAX_LEN);
  localparam int BCNT_W = $clog2(MAX_LEN * 8 + 1);
  localparam int AIW    = $clog2(ADDR_W);

  tx_state_e          state, nxt;
  seg_e               seg;
  logic [BCNT_W-1:0]  bcnt;
  logic [IDX_W-1:0]   pidx;
  logic [5:0]         len_q;
  logic               noack_q, crc16_q;
  logic [7:0]         retr_q;
  logic [3:0]         tries;
  logic [1:0]         pid;
  logic [ADDR_W-1:0]  addr_q;
  logic [CTRL_W-1:0]  ctrl_w;
  logic [15:0]        c16;
  logic [7:0]         c8;
  logic               cur_bit, last_bit, start, retry, give_up, acked;
  logic               pop_c, crc_init, tmr_load, crc_en, expire;

  assign ctrl_w = {len_q, pid, noack_q};
  assign pl_idx = pidx;

  // Bit counter runs downward, so within each segment it is the bit index.
  always_comb begin
    unique case (seg)
      G_ADDR:  cur_bit = addr_q[bcnt[AIW-1:0]];
      G_CTRL:  cur_bit = ctrl_w[bcnt[3:0]];
      G_PAY:   cur_bit = pl_byte[bcnt[2:0]];
      default: cur_bit = crc16_q ? c16[bcnt[3:0]] : c8[bcnt[2:0]];
    endcase
  end

  always_comb begin
    last_bit = (state == S_SEND) && (seg == G_CRC) && (bcnt == '0);
    start    = (state == S_IDLE) && !fifo_empty && !st_maxrt;
    acked    = (state == S_WAIT) && ack_in;
    retry    = (state == S_WAIT) && !ack_in && expire && (tries != retr_q[3:0]);
    give_up  = (state == S_WAIT) && !ack_in && expire && (tries == retr_q[3:0]);
    pop_c    = acked || (last_bit && noack_q);
    crc_init = start || retry;
    tmr_load = last_bit && !noack_q;
    crc_en   = (state == S_SEND) && (seg != G_CRC);
    nxt      = state;
    if (start || retry)   nxt = S_SEND;
    if (last_bit)         nxt = noack_q ? S_IDLE : S_WAIT;
    if (acked || give_up) nxt = S_IDLE;
  end

  arq_crc_ser #(.W(16), .POLY(16'h1021), .INIT(16'hFFFF)) u_crc16 (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en), .din(cur_bit), .crc(c16));

  arq_crc_ser #(.W(8), .POLY(8'h07), .INIT(8'hFF)) u_crc8 (
    .clk(clk), .rst(rst), .init(crc_init), .en(crc_en), .din(cur_bit), .crc(c8));

  arq_retry_timer #(.STEP_TICKS(STEP_TICKS)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .nib(retr_q[7:4]), .tick(tick_us),
    .expire(expire));

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      seg     <= G_ADDR;
      bcnt    <= '0;
      pidx    <= '0;
      len_q   <= '0;
      noack_q <= 1'b0;
      crc16_q <= 1'b0;
      retr_q  <= '0;
      tries   <= '0;
      pid     <= '0;
      addr_q  <= '0;
      tx_bit  <= 1'b0;
      tx_vld  <= 1'b0;
      tx_last <= 1'b0;
      fifo_pop <= 1'b0;
      st_done  <= 1'b0;
      st_maxrt <= 1'b0;
    end else begin
      state    <= nxt;
      tx_vld   <= (state == S_SEND);
      tx_bit   <= (state == S_SEND) && cur_bit;
      tx_last  <= last_bit;
      fifo_pop <= pop_c;
      st_done  <= pop_c   || (st_done  && !clr_done);
      st_maxrt <= give_up || (st_maxrt && !clr_maxrt);
      if (pop_c) pid <= pid + 2'd1;
      if (start) begin
        len_q   <= fifo_len;
        noack_q <= fifo_noack;
        crc16_q <= cfg_crc16;
        retr_q  <= cfg_retr;
        addr_q  <= cfg_addr;
        tries   <= '0;
      end
      if (retry) tries <= tries + 4'd1;
      if (crc_init) begin
        seg  <= G_ADDR;
        bcnt <= BCNT_W'(ADDR_W - 1);
        pidx <= '0;
      end else if (state == S_SEND && bcnt == '0) begin
        unique case (seg)
          G_ADDR: begin
            seg  <= G_CTRL;
            bcnt <= BCNT_W'(CTRL_W - 1);
          end
          G_CTRL: begin
            if (len_q != '0) begin
              seg  <= G_PAY;
              bcnt <= BCNT_W'({len_q, 3'b000}) - BCNT_W'(1);
            end else begin
              seg  <= G_CRC;
              bcnt <= crc16_q ? BCNT_W'(15) : BCNT_W'(7);
            end
          end
          G_PAY: begin
            seg  <= G_CRC;
            bcnt <= crc16_q ? BCNT_W'(15) : BCNT_W'(7);
          end
          default: seg <= G_ADDR;
        endcase
      end else if (state == S_SEND) begin
        bcnt <= bcnt - BCNT_W'(1);
        if (seg == G_PAY && bcnt[2:0] == 3'd0) pidx <= pidx + IDX_W'(1);
      end
    end
  end
endmodule

// File: rtl/arq_tx_ctrl_chk.sv
module arq_tx_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic tx_vld,
  input logic tx_last,
  input logic fifo_pop,
  input logic st_done,
  input logic st_maxrt
);
  // R1
  last_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_vld);

  // R1
  frame_contig_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_vld) |-> $past(tx_last));

  // R4
  pop_sets_done_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> st_done);

  // R4
  single_pop_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |=> !fifo_pop);

  // R7
  maxrt_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_maxrt) |-> !fifo_pop);

  // R8
  maxrt_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_vld) |-> !$past(st_maxrt, 2));
endmodule

bind arq_tx_ctrl arq_tx_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .tx_vld(tx_vld), .tx_last(tx_last),
  .fifo_pop(fifo_pop), .st_done(st_done), .st_maxrt(st_maxrt));

// File: tb/test_arq_tx_ctrl.sv
module test_arq_tx_ctrl;
  localparam int ADDR_W = 32;
  localparam int MAX_LEN = 32;
  localparam int STEP = 250;

  logic clk = 0, rst = 1, tick_us = 1, cfg_crc16 = 0, ack_in = 0;
  logic clr_done = 0, clr_maxrt = 0;
  logic [ADDR_W-1:0] cfg_addr = 32'hC3A5_1E69;
  logic [7:0] cfg_retr = 8'h00;
  logic fifo_empty, fifo_noack, fifo_pop, tx_bit, tx_vld, tx_last, st_done, st_maxrt;
  logic [5:0] fifo_len;
  logic [4:0] pl_idx;
  logic [7:0] pl_byte;

  logic [7:0] mem [0:127];
  logic [5:0] lenq [0:3];
  logic       naq [0:3];
  int head = 0, tail = 0, count = 0;

  assign fifo_empty = (count == 0);
  assign fifo_len   = lenq[head];
  assign fifo_noack = naq[head];
  assign pl_byte    = mem[head * 32 + int'(pl_idx)];

  arq_tx_ctrl #(.ADDR_W(ADDR_W), .MAX_LEN(MAX_LEN), .STEP_TICKS(STEP)) i_arq_tx_ctrl (
    .clk(clk), .rst(rst), .tick_us(tick_us), .cfg_addr(cfg_addr), .cfg_crc16(cfg_crc16),
    .cfg_retr(cfg_retr), .fifo_empty(fifo_empty), .fifo_len(fifo_len),
    .fifo_noack(fifo_noack), .pl_idx(pl_idx), .pl_byte(pl_byte), .fifo_pop(fifo_pop),
    .ack_in(ack_in), .clr_done(clr_done), .clr_maxrt(clr_maxrt), .tx_bit(tx_bit),
    .tx_vld(tx_vld), .tx_last(tx_last), .st_done(st_done), .st_maxrt(st_maxrt));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int frames = 0, nb = 0, last_nb = 0, cyc = 0, last_cyc = 0, gap = 0;
  logic fb [0:511];
  logic lf [0:511];
  logic eb [0:511];
  int exp_n = 0, crcw = 0, exp_pid = 0;

  // Queue retire and frame capture, both away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (fifo_pop) begin
      head  = (head + 1) % 4;
      count = count - 1;
    end
    if (tx_vld) begin
      if (nb == 0) gap = cyc - last_cyc;
      fb[nb] = tx_bit;
      nb++;
      if (tx_last) begin
        for (int i = 0; i < nb; i++) lf[i] = fb[i];
        last_nb  = nb;
        nb       = 0;
        frames++;
        last_cyc = cyc;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  task automatic push(input int len, input bit na, input int seed);
    for (int b = 0; b < 32; b++) mem[tail * 32 + b] = 8'(seed + b * 37 + (b >> 2));
    lenq[tail] = 6'(len);
    naq[tail]  = na;
    tail  = (tail + 1) % 4;
    count = count + 1;
  endtask

  task automatic build_exp(input int slot, input int pid, input bit c16);
    logic [15:0] crc;
    logic [8:0]  ctrl;
    logic        f;
    exp_n = 0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin eb[exp_n] = cfg_addr[i]; exp_n++; end
    ctrl = {lenq[slot], 2'(pid), naq[slot]};
    for (int i = 8; i >= 0; i--) begin eb[exp_n] = ctrl[i]; exp_n++; end
    for (int b = 0; b < int'(lenq[slot]); b++)
      for (int i = 7; i >= 0; i--) begin eb[exp_n] = mem[slot * 32 + b][i]; exp_n++; end
    crcw = c16 ? 16 : 8;
    crc  = c16 ? 16'hFFFF : 16'h00FF;
    for (int k = 0; k < exp_n; k++) begin
      if (c16) begin
        f   = crc[15] ^ eb[k];
        crc = {crc[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
      end else begin
        f   = crc[7] ^ eb[k];
        crc = {8'h00, crc[6:0], 1'b0} ^ (f ? 16'h0007 : 16'h0000);
      end
    end
    for (int i = crcw - 1; i >= 0; i--) begin eb[exp_n] = crc[i]; exp_n++; end
  endtask

  task automatic cmp_bits(input string req, input int from, input int to);
    int bad = 0;
    for (int i = from; i < to; i++) if (lf[i] !== eb[i]) bad++;
    chk(req, bad, 0);
  endtask

  task automatic cmp_frame(input string tag);
    chk({tag, " frame length"}, last_nb, exp_n);
    if (last_nb == exp_n) begin
      cmp_bits({tag, " header and payload bits"}, 0, exp_n - crcw);
      cmp_bits({tag, " CRC bits (R2)"}, exp_n - crcw, exp_n);
    end
  endtask

  task automatic wait_frame(input int k);
    while (frames < k) begin @(negedge clk); #2; end
  endtask

  task automatic wait_maxrt();
    while (!st_maxrt) begin @(negedge clk); #2; end
  endtask

  task automatic pulse_ack();
    ack_in = 1; @(negedge clk); #2; ack_in = 0;
  endtask

  task automatic pulse_clr(input bit d, input bit m);
    clr_done = d; clr_maxrt = m; @(negedge clk); #2; clr_done = 0; clr_maxrt = 0;
  endtask

  initial begin
    int slot, f0;
    repeat (4) @(posedge clk);
    #1;
    chk("R10 reset tx_vld", tx_vld, 0);
    chk("R10 reset tx_last", tx_last, 0);
    chk("R10 reset st_done", st_done, 0);
    chk("R10 reset st_maxrt", st_maxrt, 0);
    chk("R10 reset fifo_pop", fifo_pop, 0);
    @(negedge clk); #2; rst = 0;
    repeat (20) @(negedge clk);
    #2;
    chk("R10 no frame on empty queue", frames, 0);

    // R1 R2 R3 R4 R9: no-ack sweep over all lengths, CRC width alternating
    for (int L = 0; L <= MAX_LEN; L++) begin
      cfg_crc16 = L[0];
      cfg_addr  = 32'hC3A5_1E69 ^ (L * 32'h0101_0103);
      slot = tail;
      push(L, 1'b1, L * 13);
      f0 = frames;
      wait_frame(f0 + 1);
      build_exp(slot, exp_pid, cfg_crc16);
      cmp_frame("R1");
      chk("R3 packet id field", int'({lf[ADDR_W + 6], lf[ADDR_W + 7]}), exp_pid);
      chk("R4 done with final bit", st_done, 1);
      chk("R4 entry popped", count, 0);
      exp_pid = (exp_pid + 1) % 4;
      pulse_clr(1'b1, 1'b0);
      chk("R9 done cleared by clr_done", st_done, 0);
    end

    // R5 R9: acknowledge on the first attempt
    cfg_retr = 8'h05; cfg_crc16 = 1;
    slot = tail; push(4, 1'b0, 91);
    f0 = frames;
    wait_frame(f0 + 1);
    build_exp(slot, exp_pid, 1'b1);
    cmp_frame("R1 ack packet");
    chk("R9 done not yet set while waiting", st_done, 0);
    pulse_ack();
    chk("R5 done after ack", st_done, 1);
    chk("R5 entry popped after ack", count, 0);
    repeat (700) @(negedge clk);
    #2;
    chk("R5 no resend after ack", frames, f0 + 1);
    chk("R9 done stays set", st_done, 1);
    exp_pid = (exp_pid + 1) % 4;
    pulse_clr(1'b1, 1'b0);

    // R7 R8 R3: retry count sweep without acknowledge
    for (int m = 0; m < 16; m++) begin
      cfg_retr  = {4'h0, 4'(m)};
      cfg_crc16 = m[0];
      slot = tail; push(1, 1'b0, 200 + m);
      f0 = frames;
      wait_maxrt();
      chk("R7 attempts = retries + 1", frames - f0, m + 1);
      chk("R7 done stays clear", st_done, 0);
      chk("R7 entry kept", count, 1);
      build_exp(slot, exp_pid, cfg_crc16);
      cmp_frame("R3 retransmission");
      repeat (400) @(negedge clk);
      #2;
      chk("R8 no start while maxrt set", frames, f0 + m + 1);
      chk("R9 maxrt stays set", st_maxrt, 1);
      pulse_clr(1'b0, 1'b1);
      chk("R9 maxrt cleared", st_maxrt, 0);
      wait_frame(f0 + m + 2);
      cmp_frame("R8 resend after clear");
      pulse_ack();
      chk("R8 entry popped after resend ack", count, 0);
      exp_pid = (exp_pid + 1) % 4;
      pulse_clr(1'b1, 1'b0);
    end

    // R6: retry delay for several nibble values
    for (int s = 0; s < 3; s++) begin
      int nib;
      nib = (s == 0) ? 0 : (s == 1) ? 2 : 15;
      cfg_retr = {4'(nib), 4'h1};
      slot = tail; push(0, 1'b0, 7 * s);
      f0 = frames;
      wait_frame(f0 + 2);
      chk("R6 retry gap cycles", gap, (nib + 1) * STEP + 1);
      wait_maxrt();
      pulse_clr(1'b0, 1'b1);
      wait_frame(f0 + 3);
      pulse_ack();
      exp_pid = (exp_pid + 1) % 4;
      pulse_clr(1'b1, 1'b0);
    end

    // R5: acknowledge on the second attempt
    cfg_retr = 8'h03;
    slot = tail; push(3, 1'b0, 55);
    f0 = frames;
    wait_frame(f0 + 2);
    build_exp(slot, exp_pid, cfg_crc16);
    cmp_frame("R3 second attempt");
    pulse_ack();
    chk("R5 done after late ack", st_done, 1);
    repeat (1500) @(negedge clk);
    #2;
    chk("R5 no attempt after late ack", frames, f0 + 2);
    chk("R5 maxrt not set after late ack", st_maxrt, 0);

    summary();
  end
endmodule